// File: doc/BRIEF.md
# Burst Protocol Monitor

This block is a passive observer placed on the command side of a burst-capable memory port. Each clock edge it samples the master's read strobe, write strobe, burst-start strobe, the controller's ready signal, the address and the burst length. It keeps a record of the burst in progress: its direction, the address and length captured at the start, and how many beats are still owed. It raises an error whenever the master breaks the burst rules. The block only has outputs towards an observer and never drives the memory port.

Every beat, of a read burst or of a write burst, is one strobe cycle. A beat is accepted only when its strobe and ready are both high. A write burst has an extra rule: once it has started, the master must hold the write strobe high on every cycle until the last beat is accepted. The memory side cannot pause write data, so a cycle with the write strobe low inside an open write burst is an error. A cycle where ready is low and the master keeps the strobe high is a stall by the controller and is legal. A read burst may have idle cycles between its beats.

Each rule has one sticky error bit. In the cycle after a violating cycle the block also shows that cycle's rule vector and a one-cycle valid flag. All outputs are registered, so a violation sampled at clock edge k is visible from edge k onward, until the next edge.

Top module: `burst_proto_mon`

## Requirements
- R1: With `rst` high at a clock edge, `err_sticky`, `err_now`, `err_valid`, `burst_open` and `beats_left` all read zero after that edge.
- R2: A burst start (`bst_start` high, exactly one strobe high, `bsize` nonzero) opens a burst of that direction. After the edge, `beats_left` equals `bsize` minus one if `ready` was high on the start cycle, or `bsize` otherwise. Each later cycle where the burst's own strobe and `ready` are both high lowers `beats_left` by one. A strobe with `ready` low does not lower it. `burst_open` reads high exactly while `beats_left` is nonzero.
- R3: `bst_start` while a burst is open sets rule bit 0 (overlap). Any burst start ends the open burst. If the new start is well formed, the new burst replaces the old one.
- R4: `bst_start` with neither strobe high sets rule bit 1 (orphan start) and opens no burst.
- R5: Rule bit 2 (stray strobe) is set by any of these: a strobe while no burst is open and `bst_start` is low; the opposite-direction strobe inside an open burst; both strobes high on a start cycle. A start with both strobes high opens no burst.
- R6: A change of `addr` from the value captured at the start, on any cycle while the burst is open (start cycles excluded), sets rule bit 3 (address drift).
- R7: A change of `bsize` from the captured value, on any cycle while the burst is open (start cycles excluded), sets rule bit 4 (length drift).
- R8: Inside an open write burst, a cycle with `wr_req` low sets rule bit 5 (write gap). `wr_req` held high with `ready` low is not a gap. Idle cycles inside a read burst set nothing.
- R9: A burst start with `bsize` zero sets rule bit 6 (empty burst) and opens no burst.
- R10: `err_now` shows the rule vector of the previous cycle. `err_valid` is high exactly when that vector is nonzero. Every bit of `err_sticky` stays set until reset.
- R11: Traffic that obeys all the rules, including ready stalls and read idle cycles, never sets any error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Master read strobe |
| wr_req | input | 1 | Master write strobe |
| bst_start | input | 1 | Marks the first beat of a burst |
| ready | input | 1 | Controller accepts the current beat |
| addr | input | ADDR_W | Burst address |
| bsize | input | SIZE_W | Burst length in beats |
| err_sticky | output | 7 | Per-rule sticky error flags |
| err_now | output | 7 | Rules broken in the previous cycle |
| err_valid | output | 1 | One-cycle pulse after any violation |
| burst_open | output | 1 | A burst is in progress |
| beats_left | output | SIZE_W | Beats still owed by the open burst |

## Verification
The bench first runs legal traffic: write bursts with random ready stalls, and read bursts with random idle cycles. This separates a controller stall, which is legal, from a master gap, which is an error. It also shows that the beat counter follows accepted beats and ignores strobes that ready did not accept. Directed cases then break each rule on its own, including a one-beat burst that closes on its start cycle and a start that cuts into an open burst. These cases show that each rule maps to its own flag bit. A final phase of unconstrained random strobes and short lengths runs against a reference model in the bench. It finds mistakes that only appear when several rules fire in the same cycle.

// File: rtl/burst_mon_pkg.sv
package burst_mon_pkg;

    localparam int unsigned NUM_RULES = 7;

    typedef enum logic {
        KIND_READ  = 1'b0,
        KIND_WRITE = 1'b1
    } burst_kind_e;

    // Packed so that the last field is bit 0 of the flag vectors.
    typedef struct packed {
        logic empty_burst;  // bit 6
        logic write_gap;    // bit 5
        logic size_drift;   // bit 4
        logic addr_drift;   // bit 3
        logic stray;        // bit 2
        logic orphan;       // bit 1
        logic overlap;      // bit 0
    } rule_vec_t;

    function automatic logic [1:0] strobe_count(input logic rd, input logic wr);
        return {1'b0, rd} + {1'b0, wr};
    endfunction

    function automatic logic own_strobe(input burst_kind_e kind, input logic rd,
                                        input logic wr);
        return (kind == KIND_WRITE) ? wr : rd;
    endfunction

    function automatic logic other_strobe(input burst_kind_e kind, input logic rd,
                                          input logic wr);
        return (kind == KIND_WRITE) ? rd : wr;
    endfunction

endpackage

// File: rtl/bmon_tracker.sv
module bmon_tracker
    import burst_mon_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              bst_start,
    input  logic              ready,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] bsize,
    output logic              open_o,
    output burst_kind_e       kind_o,
    output logic [SIZE_W-1:0] left_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [SIZE_W-1:0] size_q_o
);

    logic [SIZE_W-1:0] left_q;
    burst_kind_e       kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;

    logic start_ok;
    logic beat_hit;

    always_comb begin
        start_ok = bst_start && (strobe_count(rd_req, wr_req) == 2'd1)
                   && (bsize != '0);
        beat_hit = (left_q != '0) && ready && own_strobe(kind_q, rd_req, wr_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            kind_q <= KIND_READ;
            addr_q <= '0;
            size_q <= '0;
        end else if (bst_start) begin
            if (start_ok) begin
                kind_q <= wr_req ? KIND_WRITE : KIND_READ;
                addr_q <= addr;
                size_q <= bsize;
                left_q <= bsize - SIZE_W'(ready);
            end else begin
                left_q <= '0;
            end
        end else if (beat_hit) begin
            left_q <= left_q - SIZE_W'(1);
        end
    end

    assign open_o   = (left_q != '0);
    assign kind_o   = kind_q;
    assign left_o   = left_q;
    assign addr_q_o = addr_q;
    assign size_q_o = size_q;

endmodule

// File: rtl/bmon_rules.sv
module bmon_rules
    import burst_mon_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SIZE_W = 4
) (
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              bst_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] bsize,
    input  logic              open_i,
    input  burst_kind_e       kind_i,
    input  logic [ADDR_W-1:0] addr_q_i,
    input  logic [SIZE_W-1:0] size_q_i,
    output rule_vec_t         rules_o
);

    logic [1:0] n_strobes;
    logic       in_body;

    always_comb begin
        n_strobes = strobe_count(rd_req, wr_req);
        in_body   = open_i && !bst_start;
        rules_o   = '0;

        if (bst_start) begin
            rules_o.overlap     = open_i;
            rules_o.orphan      = (n_strobes == 2'd0);
            rules_o.stray       = (n_strobes == 2'd2);
            rules_o.empty_burst = (bsize == '0);
        end else if (!open_i) begin
            rules_o.stray = (n_strobes != 2'd0);
        end

        if (in_body) begin
            rules_o.stray      = other_strobe(kind_i, rd_req, wr_req);
            rules_o.write_gap  = (kind_i == KIND_WRITE) && !wr_req;
            rules_o.addr_drift = (addr != addr_q_i);
            rules_o.size_drift = (bsize != size_q_i);
        end
    end

endmodule

// File: rtl/bmon_errlog.sv
module bmon_errlog
    import burst_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rule_vec_t            rules_i,
    output logic [NUM_RULES-1:0] sticky_o,
    output logic [NUM_RULES-1:0] now_o,
    output logic                 valid_o
);

    logic [NUM_RULES-1:0] hit;
    assign hit = rules_i;

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        always_ff @(posedge clk) begin
            if (rst) begin
                sticky_o[g] <= 1'b0;
                now_o[g]    <= 1'b0;
            end else begin
                sticky_o[g] <= sticky_o[g] | hit[g];
                now_o[g]    <= hit[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= |hit;
    end

endmodule

// File: rtl/burst_proto_mon.sv
module burst_proto_mon
    import burst_mon_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SIZE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic                 bst_start,
    input  logic                 ready,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SIZE_W-1:0]    bsize,
    output logic [NUM_RULES-1:0] err_sticky,
    output logic [NUM_RULES-1:0] err_now,
    output logic                 err_valid,
    output logic                 burst_open,
    output logic [SIZE_W-1:0]    beats_left
);

    burst_kind_e       cur_kind;
    logic              cur_is_wr;
    logic [ADDR_W-1:0] cap_addr;
    logic [SIZE_W-1:0] cap_size;
    rule_vec_t         rules;

    bmon_tracker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) tracker_i (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .bst_start(bst_start),
        .ready    (ready),
        .addr     (addr),
        .bsize    (bsize),
        .open_o   (burst_open),
        .kind_o   (cur_kind),
        .left_o   (beats_left),
        .addr_q_o (cap_addr),
        .size_q_o (cap_size)
    );

    assign cur_is_wr = (cur_kind == KIND_WRITE);

    bmon_rules #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) rules_i (
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .bst_start(bst_start),
        .addr     (addr),
        .bsize    (bsize),
        .open_i   (burst_open),
        .kind_i   (cur_kind),
        .addr_q_i (cap_addr),
        .size_q_i (cap_size),
        .rules_o  (rules)
    );

    bmon_errlog errlog_i (
        .clk     (clk),
        .rst     (rst),
        .rules_i (rules),
        .sticky_o(err_sticky),
        .now_o   (err_now),
        .valid_o (err_valid)
    );

endmodule

// File: rtl/burst_proto_mon_chk.sv
module burst_proto_mon_chk #(
    parameter int unsigned SIZE_W = 4,
    parameter int unsigned NR     = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              wr_req,
    input logic              bst_start,
    input logic              ready,
    input logic [NR-1:0]     err_sticky,
    input logic [NR-1:0]     err_now,
    input logic              err_valid,
    input logic              burst_open,
    input logic [SIZE_W-1:0] beats_left,
    input logic              is_wr
);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (err_sticky == '0 && err_now == '0 && !err_valid && !burst_open));

    p_beat_counts_down_r2: assert property (@(posedge clk) disable iff (rst)
        (burst_open && !bst_start && ready && (is_wr ? wr_req : rd_req))
        |=> (beats_left == $past(beats_left) - SIZE_W'(1)));

    p_no_accept_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (burst_open && !bst_start && !ready) |=> $stable(beats_left));

    p_overlap_flagged_r3: assert property (@(posedge clk) disable iff (rst)
        (burst_open && bst_start) |=> (err_now[0] && err_valid));

    p_idle_stray_r5: assert property (@(posedge clk) disable iff (rst)
        (!burst_open && !bst_start && (rd_req || wr_req)) |=> err_now[2]);

    p_write_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (burst_open && is_wr && !bst_start && !wr_req) |=> err_now[5]);

    p_sticky_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    p_sticky_covers_now_r10: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ((err_sticky & err_now) == err_now));

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        err_valid == (err_now != '0));

endmodule

bind burst_proto_mon burst_proto_mon_chk #(.SIZE_W(SIZE_W), .NR(7)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .bst_start (bst_start),
    .ready     (ready),
    .err_sticky(err_sticky),
    .err_now   (err_now),
    .err_valid (err_valid),
    .burst_open(burst_open),
    .beats_left(beats_left),
    .is_wr     (cur_is_wr)
);

// File: tb/burst_proto_mon_tb_top.sv
module burst_proto_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_req = 1'b0, wr_req = 1'b0, bst_start = 1'b0, ready = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [SW-1:0] bsize = '0;
    logic [6:0]    err_sticky, err_now;
    logic          err_valid, burst_open;
    logic [SW-1:0] beats_left;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic          m_open, m_wr;
    logic [SW-1:0] m_left, m_size;
    logic [AW-1:0] m_addr;
    logic [6:0]    m_sticky, m_now;
    logic          m_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_proto_mon #(.ADDR_W(AW), .SIZE_W(SW)) dut_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
        .bst_start(bst_start), .ready(ready), .addr(addr), .bsize(bsize),
        .err_sticky(err_sticky), .err_now(err_now), .err_valid(err_valid),
        .burst_open(burst_open), .beats_left(beats_left)
    );

    // Rule bits: 0 overlap, 1 orphan, 2 stray, 3 addr drift, 4 size drift,
    // 5 write gap, 6 empty burst.
    function automatic logic [6:0] model_rules(input logic r, w, b,
                                               input logic [AW-1:0] a,
                                               input logic [SW-1:0] s);
        logic [6:0] e = '0;
        if (b) begin
            e[0] = m_open;
            e[1] = !r && !w;
            e[2] = r && w;
            e[6] = (s == '0);
        end else if (m_open) begin
            e[2] = m_wr ? r : w;
            e[5] = m_wr && !w;
            e[3] = (a != m_addr);
            e[4] = (s != m_size);
        end else begin
            e[2] = r || w;
        end
        return e;
    endfunction

    task automatic model_step(input logic r, w, b, y, input logic [AW-1:0] a,
                              input logic [SW-1:0] s);
        logic [6:0] e;
        e = model_rules(r, w, b, a, s);
        if (b) begin
            if ((r ^ w) && s != '0) begin
                m_wr   = w;
                m_addr = a;
                m_size = s;
                m_left = s - SW'(y);
            end else begin
                m_left = '0;
            end
        end else if (m_open && y && (m_wr ? w : r)) begin
            m_left = m_left - SW'(1);
        end
        m_open   = (m_left != '0);
        m_now    = e;
        m_valid  = (e != '0);
        m_sticky = m_sticky | e;
    endtask

    task automatic model_clear();
        m_open = 0; m_wr = 0; m_left = '0; m_size = '0; m_addr = '0;
        m_sticky = '0; m_now = '0; m_valid = 0;
    endtask

    task automatic compare(input string tag);
        logic [19:0] got, exp;
        got = {err_valid, err_now, err_sticky, burst_open, beats_left};
        exp = {m_valid, m_now, m_sticky, m_open, m_left};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got valid=%b now=%b sticky=%b open=%b left=%0d exp valid=%b now=%b sticky=%b open=%b left=%0d",
                     tag, got[19], got[18:12], got[11:5], got[4], got[3:0],
                     exp[19], exp[18:12], exp[11:5], exp[4], exp[3:0]);
        end
    endtask

    task automatic step(input logic r, w, b, y, input logic [AW-1:0] a,
                        input logic [SW-1:0] s, input string tag);
        @(negedge clk);
        rd_req = r; wr_req = w; bst_start = b; ready = y; addr = a; bsize = s;
        model_step(r, w, b, y, a, s);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rd_req = 0; wr_req = 0; bst_start = 0; ready = 0;
        repeat (2) @(posedge clk);
        #1;
        model_clear();
        compare("R1 reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic legal_burst(input logic is_w, input logic [SW-1:0] s);
        logic [AW-1:0] a;
        a = AW'($urandom);
        step(!is_w, is_w, 1'b1, 1'($urandom), a, s, "R2 start");
        while (m_open) begin
            if (is_w)
                step(1'b0, 1'b1, 1'b0, ($urandom % 3) != 0, a, s, "R11 write body");
            else
                step(($urandom % 4) != 0, 1'b0, 1'b0, 1'($urandom), a, s, "R11 read body");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();

        // R2/R8: write burst of 4 with a controller stall (legal).
        step(0, 1, 1, 1, 16'h0100, 4'd4, "R2 write start");
        step(0, 1, 0, 0, 16'h0100, 4'd4, "R8 ready stall no gap");
        step(0, 1, 0, 1, 16'h0100, 4'd4, "R2 beat");
        step(0, 1, 0, 1, 16'h0100, 4'd4, "R2 beat");
        step(0, 1, 0, 1, 16'h0100, 4'd4, "R2 last beat closes");
        // R2/R8: read burst of 3, start not accepted, idle gap allowed.
        step(1, 0, 1, 0, 16'h0200, 4'd3, "R2 read start no accept");
        step(0, 0, 0, 1, 16'h0200, 4'd3, "R8 read idle allowed");
        step(1, 0, 0, 1, 16'h0200, 4'd3, "R2 read beat");
        step(1, 0, 0, 1, 16'h0200, 4'd3, "R2 read beat");
        step(1, 0, 0, 1, 16'h0200, 4'd3, "R2 read last");
        // R2: single-beat burst closes on its start cycle.
        step(0, 1, 1, 1, 16'h0300, 4'd1, "R2 one beat");

        // R3: start cuts into open burst; new burst replaces it.
        step(0, 1, 1, 1, 16'h0400, 4'd4, "R3 first start");
        step(1, 0, 1, 1, 16'h0500, 4'd2, "R3 overlap start");
        step(1, 0, 0, 1, 16'h0500, 4'd2, "R3 new burst finishes");
        do_reset();

        // R4: orphan start.
        step(0, 0, 1, 1, 16'h0600, 4'd2, "R4 orphan start");
        step(0, 0, 0, 0, 16'h0600, 4'd2, "R4 nothing opened");
        do_reset();

        // R5: stray cases.
        step(0, 1, 0, 1, 16'h0700, 4'd2, "R5 idle write strobe");
        step(1, 1, 1, 1, 16'h0700, 4'd2, "R5 both strobes on start");
        step(0, 1, 1, 0, 16'h0700, 4'd2, "R5 write start");
        step(1, 1, 0, 0, 16'h0700, 4'd2, "R5 read inside write");
        do_reset();

        // R6/R7: drift inside a read burst.
        step(1, 0, 1, 1, 16'h0800, 4'd3, "R6 read start");
        step(1, 0, 0, 0, 16'h0801, 4'd3, "R6 addr drift");
        step(1, 0, 0, 0, 16'h0800, 4'd5, "R7 size drift");
        do_reset();

        // R8: master gap in write burst.
        step(0, 1, 1, 1, 16'h0900, 4'd3, "R8 write start");
        step(0, 0, 0, 1, 16'h0900, 4'd3, "R8 write gap");
        do_reset();

        // R9: empty burst.
        step(0, 1, 1, 1, 16'h0A00, 4'd0, "R9 empty start");
        step(0, 0, 0, 0, 16'h0A00, 4'd0, "R9 nothing opened");
        do_reset();

        // R11: random legal traffic.
        for (int i = 0; i < 80; i++) begin
            legal_burst(1'($urandom), SW'(1 + ($urandom % 15)));
            for (int k = 0; k < int'($urandom % 3); k++)
                step(0, 0, 0, 1'($urandom), AW'($urandom), SW'($urandom), "R11 idle");
        end
        do_reset();

        // R10: unconstrained traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
                 1'($urandom), AW'($urandom % 2), SW'($urandom % 4), "R10 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule